// File: doc/BRIEF.md
# Type-C Alternate-Mode Lane Mux Controller

This block is the control logic for a USB Type-C crosspoint switch that is configured by strap pins rather than by registers. Three asynchronous control levels (a DisplayPort enable, a mode bit and a plug-orientation bit) are synchronized to a free-running clock. They are then decoded into one of four operating states: power down, USB only, four-lane DisplayPort, or USB plus two-lane DisplayPort. Each state exists in a normal and a flipped orientation. For each of the four connector high-speed pairs (TX1, RX1, TX2, RX2) the block drives a route-select code, and it drives a separate select for the AUX-to-sideband path.

After reset the block is held in USB mode whatever the pin levels are. A port controller releases it by pulsing the mode pin low-high-low. From then on the decoded pin configuration applies. The AUX path follows the orientation bit while DisplayPort is enabled. It is disconnected only after the enable has stayed low for a programmable time, 2 ms by default. A shorter low keeps the last mapping.

Top module: `lane_mux_ctrl`

## Requirements
- R1: After reset the outputs show the forced USB state. cfg_code is 3'b010, dp_en is 0, aux_sel is 0 (open), and with flip low sel_tx1 and sel_rx1 are 1 (USB) while sel_tx2 and sel_rx2 are 0.
- R2: Until released, cfg_code is {1'b0, 1'b1, flip} and dp_en is 0, whatever the level of ctl1_pin. Flip low routes TX1/RX1 to USB, and flip high routes TX2/RX2 to USB.
- R3: The forced state ends only after the synchronized ctl0_pin is seen high and then low. It never re-enters forced mode until the next reset.
- R4: Once released, a configuration with ctl1 low and ctl0 low (power down) drives route code 0 on all four pairs, at either flip level.
- R5: Once released, ctl1 low with ctl0 high selects USB only. Flip low gives TX1=RX1=1, and flip high gives TX2=RX2=1. The other two pairs get 0.
- R6: Once released, ctl1 high with ctl0 low selects four-lane DisplayPort, where route code 4+n means lane DPn. Flip low gives TX2=4, RX2=5, RX1=6, TX1=7. Flip high gives TX1=4, RX1=5, RX2=6, TX2=7.
- R7: Once released, ctl1 high with ctl0 high selects USB plus two-lane DisplayPort. Flip low gives TX1=RX1=1, TX2=4, RX2=5. Flip high gives TX2=RX2=1, TX1=4, RX1=5.
- R8: Once released, cfg_code equals {ctl1, ctl0, flip} and dp_en equals ctl1.
- R9: While released with ctl1 high, aux_sel is 1 when flip is low (sideband 1 to AUX negative, sideband 2 to AUX positive) and 2 when flip is high (swapped).
- R10: aux_sel becomes 0 (open) only after ctl1 has been low for AUX_OPEN_US microseconds of clock cycles. A shorter low leaves the previous mapping unchanged.
- R11: Route code 0 is reserved for a disconnected pair and is driven on every pair that the active configuration does not use.
- R12: A change on the pins reaches all outputs within three clock cycles: two synchronizer stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl1_pin | input | 1 | Asynchronous DisplayPort enable level |
| ctl0_pin | input | 1 | Asynchronous mode level, also the release pulse |
| flip_pin | input | 1 | Asynchronous plug orientation level |
| sel_tx1 | output | 3 | Route code for connector pair TX1 |
| sel_rx1 | output | 3 | Route code for connector pair RX1 |
| sel_tx2 | output | 3 | Route code for connector pair TX2 |
| sel_rx2 | output | 3 | Route code for connector pair RX2 |
| aux_sel | output | 2 | AUX-to-sideband select: 0 open, 1 normal, 2 swapped |
| cfg_code | output | 3 | Active configuration {ctl1, ctl0, flip} |
| dp_enable | output | 1 | DisplayPort enabled in the active configuration |

## Verification
The assertions assume that the three pins change together and then hold for several clock cycles, so the synchronized copies stay mutually consistent. They also assume that ctl0 is low while reset is applied, so that the first rise after reset is a real release edge. The stimulus changes pins only on falling clock edges, holds each random pattern for six cycles, and keeps ctl0 low through reset and through the forced-mode checks until the deliberate release pulse. The AUX timeout is checked at points well inside and well beyond the threshold, so that exact edge alignment does not decide the result.

// File: rtl/lmx_pkg.sv
// Package: shared codes and the configuration decoder for the lane mux controller.
// Assumes a configuration word of {ctl1, ctl0, flip}.
package lmx_pkg;

    localparam int ROUTE_W = 3;
    localparam logic [ROUTE_W-1:0] RT_OPEN = 3'd0;
    localparam logic [ROUTE_W-1:0] RT_USB  = 3'd1;
    localparam logic [ROUTE_W-1:0] RT_DP0  = 3'd4;
    localparam logic [ROUTE_W-1:0] RT_DP1  = 3'd5;
    localparam logic [ROUTE_W-1:0] RT_DP2  = 3'd6;
    localparam logic [ROUTE_W-1:0] RT_DP3  = 3'd7;

    localparam logic [1:0] AUX_OPEN = 2'd0;
    localparam logic [1:0] AUX_NORM = 2'd1;
    localparam logic [1:0] AUX_SWAP = 2'd2;

    typedef enum logic [1:0] {
        RL_WAIT_HI = 2'd0,
        RL_WAIT_LO = 2'd1,
        RL_RUN     = 2'd2
    } release_state_t;

    typedef struct packed {
        logic [ROUTE_W-1:0] tx1;
        logic [ROUTE_W-1:0] rx1;
        logic [ROUTE_W-1:0] tx2;
        logic [ROUTE_W-1:0] rx2;
    } lane_routes_t;

    // Map a configuration word to the route code of each connector pair.
    function automatic lane_routes_t route_decode(logic [2:0] cfg);
        lane_routes_t r;
        r.tx1 = RT_OPEN;
        r.rx1 = RT_OPEN;
        r.tx2 = RT_OPEN;
        r.rx2 = RT_OPEN;
        case (cfg[2:1])
            2'b01: begin
                if (cfg[0]) begin
                    r.tx2 = RT_USB;
                    r.rx2 = RT_USB;
                end else begin
                    r.tx1 = RT_USB;
                    r.rx1 = RT_USB;
                end
            end
            2'b10: begin
                if (cfg[0]) begin
                    r.tx1 = RT_DP0;
                    r.rx1 = RT_DP1;
                    r.rx2 = RT_DP2;
                    r.tx2 = RT_DP3;
                end else begin
                    r.tx2 = RT_DP0;
                    r.rx2 = RT_DP1;
                    r.rx1 = RT_DP2;
                    r.tx1 = RT_DP3;
                end
            end
            2'b11: begin
                if (cfg[0]) begin
                    r.tx2 = RT_USB;
                    r.rx2 = RT_USB;
                    r.tx1 = RT_DP0;
                    r.rx1 = RT_DP1;
                end else begin
                    r.tx1 = RT_USB;
                    r.rx1 = RT_USB;
                    r.tx2 = RT_DP0;
                    r.rx2 = RT_DP1;
                end
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lmx_sync.sv
// Module: multi-stage synchronizer for a bus of independent level inputs.
// Assumes the inputs are slow levels; each bit is synchronized on its own.
module lmx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the asynchronous levels.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_async;
            end
        end else begin : g_next
            // Pass the value on to the next stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/lmx_release.sv
// Module: holds the block in forced USB mode after reset until the synchronized
// mode bit is seen high and then low. Assumes ctl0 is low while reset is applied.
module lmx_release (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl0_s,
    output logic released
);
    import lmx_pkg::*;

    release_state_t state_q;

    // Step through the wait-high, wait-low and run states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RL_WAIT_HI;
        end else begin
            case (state_q)
                RL_WAIT_HI: if (ctl0_s)  state_q <= RL_WAIT_LO;
                RL_WAIT_LO: if (!ctl0_s) state_q <= RL_RUN;
                default:                 state_q <= RL_RUN;
            endcase
        end
    end

    assign released = (state_q == RL_RUN);

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        released |=> released)
        else $error("release state left before reset");

    p_release_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(released) |-> !$past(ctl0_s))
        else $error("release without ctl0 low");

endmodule

// File: rtl/lmx_aux_path.sv
// Module: AUX-to-sideband select. Follows the orientation while DisplayPort is
// enabled and opens the path after TIMEOUT_CYC consecutive low cycles of the enable.
// Assumes TIMEOUT_CYC is at least 2.
module lmx_aux_path #(
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl1_eff,
    input  logic       flip_s,
    output logic [1:0] aux_sel
);
    import lmx_pkg::*;

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] TO_C   = CNT_W'(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] TO_M1  = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] low_cnt;

    // Count low cycles of the enable, saturating at the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)              low_cnt <= '0;
        else if (ctl1_eff)       low_cnt <= '0;
        else if (low_cnt != TO_C) low_cnt <= low_cnt + 1'b1;
    end

    // Track orientation while enabled; open once the timeout is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)                aux_sel <= AUX_OPEN;
        else if (ctl1_eff)         aux_sel <= flip_s ? AUX_SWAP : AUX_NORM;
        else if (low_cnt == TO_M1) aux_sel <= AUX_OPEN;
    end

    p_aux_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl1_eff && low_cnt != TO_M1) |=> $stable(aux_sel))
        else $error("aux select changed before timeout");

    p_aux_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl1_eff |=> (aux_sel != AUX_OPEN))
        else $error("aux open while enabled");

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= TO_C)
        else $error("low counter overran");

endmodule

// File: rtl/lane_mux_ctrl.sv
// Module: top of the Type-C lane mux controller. Synchronizes the three strap
// levels, applies forced USB mode until released, and registers route codes,
// the configuration code and the AUX select. Assumes the pins are slow levels.
module lane_mux_ctrl #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int AUX_OPEN_US = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl1_pin,
    input  logic       ctl0_pin,
    input  logic       flip_pin,
    output logic [2:0] sel_tx1,
    output logic [2:0] sel_rx1,
    output logic [2:0] sel_tx2,
    output logic [2:0] sel_rx2,
    output logic [1:0] aux_sel,
    output logic [2:0] cfg_code,
    output logic       dp_enable
);
    import lmx_pkg::*;

    localparam int TIMEOUT_CYC = (CLK_HZ / 1_000_000) * AUX_OPEN_US;

    logic [2:0]   pins_s;
    logic         released;
    logic [2:0]   cfg_eff;
    logic         ctl1_eff;
    lane_routes_t routes;

    lmx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ctl1_pin, ctl0_pin, flip_pin}),
        .q_sync  (pins_s)
    );

    lmx_release u_release (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl0_s   (pins_s[1]),
        .released (released)
    );

    // Choose the live pin word or the forced USB word.
    always_comb begin
        cfg_eff  = released ? pins_s : {1'b0, 1'b1, pins_s[0]};
        ctl1_eff = released & pins_s[2];
        routes   = route_decode(cfg_eff);
    end

    lmx_aux_path #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_aux (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl1_eff (ctl1_eff),
        .flip_s   (pins_s[0]),
        .aux_sel  (aux_sel)
    );

    // Register the decoded configuration and route codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_code  <= 3'b010;
            dp_enable <= 1'b0;
            sel_tx1   <= RT_USB;
            sel_rx1   <= RT_USB;
            sel_tx2   <= RT_OPEN;
            sel_rx2   <= RT_OPEN;
        end else begin
            cfg_code  <= cfg_eff;
            dp_enable <= ctl1_eff;
            sel_tx1   <= routes.tx1;
            sel_rx1   <= routes.rx1;
            sel_tx2   <= routes.tx2;
            sel_rx2   <= routes.rx2;
        end
    end

    p_forced_usb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !released |=> (cfg_code[2:1] == 2'b01 && !dp_enable))
        else $error("forced USB not applied");

    p_pwrdn_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_code[2:1] == 2'b00) |->
        (sel_tx1 == RT_OPEN && sel_rx1 == RT_OPEN && sel_tx2 == RT_OPEN && sel_rx2 == RT_OPEN))
        else $error("power down with a connected pair");

    p_dp4_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_code[2:1] == 2'b10) |->
        (sel_tx1[2] && sel_rx1[2] && sel_tx2[2] && sel_rx2[2]))
        else $error("four-lane mode with a non-DP pair");

    p_usb_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_code[2:1] == 2'b01) |->
        ((sel_tx1 == RT_USB) == (sel_rx1 == RT_USB) && (sel_tx2 == RT_USB) == (sel_rx2 == RT_USB)
         && (sel_tx1 == RT_OPEN) != (sel_tx2 == RT_OPEN)))
        else $error("USB mode pair mismatch");

endmodule

// File: tb/lane_mux_ctrl_test.sv
module lane_mux_ctrl_test;

    localparam int TO_US  = 20;
    localparam int TO_CYC = 50 * TO_US;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl1 = 1'b0, ctl0 = 1'b0, flip = 1'b0;
    logic [2:0] sel_tx1, sel_rx1, sel_tx2, sel_rx2, cfg_code;
    logic [1:0] aux_sel;
    logic       dp_enable;

    int checks = 0;
    int errors = 0;
    logic [1:0] aux_model = 2'd0;

    always #10 clk = ~clk;

    lane_mux_ctrl #(.CLK_HZ(50_000_000), .AUX_OPEN_US(TO_US)) uut (
        .clk(clk), .rst_n(rst_n), .ctl1_pin(ctl1), .ctl0_pin(ctl0), .flip_pin(flip),
        .sel_tx1(sel_tx1), .sel_rx1(sel_rx1), .sel_tx2(sel_tx2), .sel_rx2(sel_rx2),
        .aux_sel(aux_sel), .cfg_code(cfg_code), .dp_enable(dp_enable)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected route codes packed {tx1, rx1, tx2, rx2} from the requirements.
    function automatic logic [11:0] exp_routes(logic c1, logic c0, logic f);
        logic [2:0] t1 = 0, r1 = 0, t2 = 0, r2 = 0;
        if (!c1 && c0) begin            // R5
            if (f) begin t2 = 1; r2 = 1; end else begin t1 = 1; r1 = 1; end
        end else if (c1 && !c0) begin   // R6
            if (f) begin t1 = 4; r1 = 5; r2 = 6; t2 = 7; end
            else   begin t2 = 4; r2 = 5; r1 = 6; t1 = 7; end
        end else if (c1 && c0) begin    // R7
            if (f) begin t2 = 1; r2 = 1; t1 = 4; r1 = 5; end
            else   begin t1 = 1; r1 = 1; t2 = 4; r2 = 5; end
        end
        return {t1, r1, t2, r2};
    endfunction

    task automatic drive(logic c1, logic c0, logic f);
        @(negedge clk);
        ctl1 = c1; ctl0 = c0; flip = f;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_routes(string req, logic c1, logic c0, logic f);
        check(req, {sel_tx1, sel_rx1, sel_tx2, sel_rx2}, exp_routes(c1, c0, f));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5a17));
        settle(4);
        rst_n = 1'b1;
        settle(1);
        // R1: reset state
        check("R1 cfg", cfg_code, 3'b010);
        check("R1 dp", dp_enable, 0);
        check("R1 aux", aux_sel, 0);
        check_routes("R1 routes", 0, 1, 0);

        // R2: forced USB ignores ctl1, follows flip; R12 latency of 3 cycles
        drive(1, 0, 1);
        settle(3);
        check("R12 R2 cfg", cfg_code, 3'b011);
        check("R2 dp", dp_enable, 0);
        check_routes("R2 flip", 0, 1, 1);
        check("R2 aux", aux_sel, 0);
        drive(1, 0, 0);
        settle(5);
        check_routes("R2 noflip", 0, 1, 0);

        // R3: release with ctl0 low-high-low
        drive(1, 1, 0);
        settle(6);
        check("R3 still forced while high", cfg_code, 3'b010);
        drive(1, 0, 0);
        settle(6);
        check("R3 released cfg", cfg_code, 3'b100);
        check("R8 dp", dp_enable, 1);
        check_routes("R6 after release", 1, 0, 0);
        check("R9 aux norm", aux_sel, 1);
        aux_model = 2'd1;

        // Directed corners: each configuration once
        for (int k = 0; k < 8; k++) begin
            drive(k[2], k[1], k[0]);
            settle(6);
            if (k[2]) aux_model = k[0] ? 2'd2 : 2'd1;
            check("R8 cfg", cfg_code, k);
            check_routes(k[2:1] == 0 ? "R4 routes" : "R11 routes", k[2], k[1], k[0]);
            check("R9 aux", aux_sel, aux_model);
        end

        // Random patterns
        for (int i = 0; i < 60; i++) begin
            logic [2:0] p = 3'($urandom_range(0, 7));
            drive(p[2], p[1], p[0]);
            settle(6);
            if (p[2]) aux_model = p[0] ? 2'd2 : 2'd1;
            check("R8 rand cfg", cfg_code, p);
            check("R8 rand dp", dp_enable, p[2]);
            check_routes("R5 R6 R7 rand", p[2], p[1], p[0]);
            check("R9 R10 rand aux", aux_sel, aux_model);
        end

        // R10: short low keeps mapping, long low opens it
        drive(1, 1, 1);
        settle(6);
        check("R9 swap", aux_sel, 2);
        drive(0, 1, 0);
        settle(TO_CYC - 20);
        check("R10 short low keeps", aux_sel, 2);
        drive(1, 1, 0);
        settle(6);
        check("R9 norm", aux_sel, 1);
        drive(0, 0, 1);
        settle(TO_CYC + 20);
        check("R10 long low opens", aux_sel, 0);
        check_routes("R4 pwrdn flip", 0, 0, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule